// File: doc/BRIEF.md
# Two-Wire Command Receiver for a Dual Digital Resistor

This block is the serial front end of a two-channel digital resistor controller. It watches an I2C bus through a fast system clock that oversamples SCL and SDA. It finds START and STOP conditions and answers one 7-bit slave address. The upper five address bits are fixed at `01011`. The lower two bits come from two strap pins.

A write frame carries an instruction byte and an optional data byte. When the frame is complete, the block hands the pair to the controller core on a valid/ready command port. A read frame shifts out a byte that the core supplies on `rd_byte`. The block takes part in the bus only by pulling SDA low through `sda_oe`. It never stretches the clock.

The data byte can be narrowed to 6 bits with a parameter. In that case bits 7 and 6 of every delivered data byte are zero.

Top module: `pot_i2c_rx`

## Requirements
- R1: After reset `sda_oe` and `cmd_valid` are 0.
- R2: A byte whose upper seven bits equal `0,1,0,1,1,addr_pin1,addr_pin0` (transmitted MSB first, R/W last, 1 = read) is acknowledged: `sda_oe` is 1 over the following ninth SCL high phase. Instruction and data bytes of such a write are acknowledged the same way.
- R3: After an address that does not match, `sda_oe` stays 0 for every later byte until the next START, and no command is produced.
- R4: A write of address, instruction and data yields one command with `cmd_instr` = instruction, `cmd_data` = data and `cmd_has_data` = 1. Bits are taken MSB first on SCL rising edges.
- R5: A write frame closed by STOP or repeated START right after the instruction acknowledge yields one command with `cmd_has_data` = 0 and `cmd_data` = 0.
- R6: A STOP that arrives after at least one complete bit of the instruction or data byte yields no command.
- R7: With `DATA_BITS` = 6, bits 7 and 6 of `cmd_data` are always 0. With 8, all eight bits are kept.
- R8: In a read, the `rd_byte` value present at the address acknowledge is driven MSB first, one bit per SCL clock. A 0 bit is shown as `sda_oe` = 1. Later changes of `rd_byte` do not alter that byte.
- R9: A master ACK (SDA low) after a read byte loads `rd_byte` again and sends another byte. A master NACK releases SDA until the next START.
- R10: While `cmd_valid` = 1 and `cmd_ready` = 0, the command fields are held stable. A command completing in that time is dropped. A transfer takes place on a clock where both `cmd_valid` and `cmd_ready` are 1.
- R11: Write bytes after the data byte are not acknowledged and produce no further command.
- R12: `sda_oe` only changes while the synchronized SCL is low, or at a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_pin1 | input | 1 | Address bit 1 strap |
| addr_pin0 | input | 1 | Address bit 0 strap |
| rd_byte | input | 8 | Byte returned on reads |
| cmd_valid | output | 1 | Command available |
| cmd_ready | input | 1 | Core accepts the command |
| cmd_instr | output | 8 | Instruction byte |
| cmd_data | output | 8 | Data byte (masked to DATA_BITS) |
| cmd_has_data | output | 1 | 1 when a data byte was received |

## Verification
The hardest case to produce is the difference between an empty data byte and a truncated one. Both STOP and repeated START begin with an SCL rise that the receiver cannot tell from the first data bit. The stimulus closes one frame right after the instruction acknowledge, another with a repeated START, and a third after four real data bits. A command must appear for the first two and not for the third. Back-pressure is reached by holding `cmd_ready` low across two complete write frames, and then checking that only the first command emerges.

// File: rtl/pot_i2c_pkg.sv
package pot_i2c_pkg;
  localparam logic [4:0] ADDR_HI = 5'b01011;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_ACK0, S_ACK1, S_TX, S_RACK
  } eng_st_t;

  typedef struct packed {
    logic [7:0] instr;
    logic [7:0] data;
    logic       has_data;
  } cmd_t;
endpackage

// File: rtl/pot_i2c_sync.sv
module pot_i2c_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '1;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/pot_i2c_cond.sv
module pot_i2c_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/pot_i2c_engine.sv
module pot_i2c_engine
  import pot_i2c_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [1:0] addr_lo,
  input  logic [7:0] rd_byte,
  output logic       sda_oe,
  output logic       engaged,
  output logic       evt_valid,
  output cmd_t       evt_cmd
);
  localparam logic [7:0] DMASK = 8'((9'd1 << DATA_BITS) - 9'd1);

  eng_st_t    st;
  logic [3:0] bitcnt;
  logic [1:0] byte_idx;
  logic [7:0] sh, tx_sh, instr;
  logic       rw, mack;
  logic [7:0] full;
  logic       frame_end, instr_only;

  assign full       = {sh[6:0], sda_s};
  assign frame_end  = start_det | stop_det;
  // the closing condition adds one SCL rise of its own, so bitcnt <= 1
  assign instr_only = (st == S_RX) && (byte_idx == 2'd2) && (bitcnt <= 4'd1) && !rw;
  assign engaged    = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      bitcnt    <= '0;
      byte_idx  <= '0;
      sh        <= '0;
      tx_sh     <= '0;
      instr     <= '0;
      rw        <= 1'b0;
      mack      <= 1'b0;
      sda_oe    <= 1'b0;
      evt_valid <= 1'b0;
      evt_cmd   <= '0;
    end else begin
      evt_valid <= 1'b0;
      if (frame_end) begin
        if (instr_only) begin
          evt_valid <= 1'b1;
          evt_cmd   <= '{instr: instr, data: 8'h00, has_data: 1'b0};
        end
        sda_oe   <= 1'b0;
        bitcnt   <= '0;
        byte_idx <= '0;
        rw       <= 1'b0;
        st       <= start_det ? S_RX : S_IDLE;
      end else begin
        unique case (st)
          S_RX: if (scl_rise) begin
            sh <= full;
            if (bitcnt != 4'd7) begin
              bitcnt <= bitcnt + 4'd1;
            end else begin
              bitcnt <= '0;
              unique case (byte_idx)
                2'd0: begin
                  if (full[7:1] == {ADDR_HI, addr_lo}) begin
                    rw       <= full[0];
                    byte_idx <= 2'd1;
                    st       <= S_ACK0;
                  end else begin
                    st <= S_IDLE;
                  end
                end
                2'd1: begin
                  instr    <= full;
                  byte_idx <= 2'd2;
                  st       <= S_ACK0;
                end
                2'd2: begin
                  evt_valid <= 1'b1;
                  evt_cmd   <= '{instr: instr, data: full & DMASK, has_data: 1'b1};
                  byte_idx  <= 2'd3;
                  st        <= S_ACK0;
                end
                default: st <= S_IDLE;
              endcase
            end
          end
          S_ACK0: if (scl_fall) begin
            sda_oe <= 1'b1;
            st     <= S_ACK1;
            if (rw) tx_sh <= rd_byte;
          end
          S_ACK1: if (scl_fall) begin
            bitcnt <= '0;
            if (rw) begin
              sda_oe <= ~tx_sh[7];
              st     <= S_TX;
            end else begin
              sda_oe <= 1'b0;
              st     <= S_RX;
            end
          end
          S_TX: if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              sda_oe <= 1'b0;
              st     <= S_RACK;
            end else begin
              sda_oe <= ~tx_sh[6];
              tx_sh  <= {tx_sh[6:0], 1'b0};
              bitcnt <= bitcnt + 4'd1;
            end
          end
          S_RACK: begin
            if (scl_rise) mack <= ~sda_s;
            if (scl_fall) begin
              if (mack) begin
                tx_sh  <= rd_byte;
                sda_oe <= ~rd_byte[7];
                bitcnt <= '0;
                st     <= S_TX;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pot_i2c_rx.sv
module pot_i2c_rx
  import pot_i2c_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       addr_pin1,
  input  logic       addr_pin0,
  input  logic [7:0] rd_byte,
  output logic       cmd_valid,
  input  logic       cmd_ready,
  output logic [7:0] cmd_instr,
  output logic [7:0] cmd_data,
  output logic       cmd_has_data
);
  logic [1:0] bus_s;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, start_det, stop_det;
  logic       engaged, evt_valid;
  cmd_t       evt_cmd, hold;

  pot_i2c_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(bus_s)
  );
  assign scl_s = bus_s[1];
  assign sda_s = bus_s[0];

  pot_i2c_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  pot_i2c_engine #(.DATA_BITS(DATA_BITS)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .addr_lo({addr_pin1, addr_pin0}), .rd_byte(rd_byte),
    .sda_oe(sda_oe), .engaged(engaged),
    .evt_valid(evt_valid), .evt_cmd(evt_cmd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      hold      <= '0;
    end else begin
      if (cmd_valid && cmd_ready) cmd_valid <= 1'b0;
      if (evt_valid && (!cmd_valid || cmd_ready)) begin
        cmd_valid <= 1'b1;
        hold      <= evt_cmd;
      end
    end
  end

  assign cmd_instr    = hold.instr;
  assign cmd_data     = hold.data;
  assign cmd_has_data = hold.has_data;
endmodule

// File: rtl/pot_i2c_rx_chk.sv
module pot_i2c_rx_chk #(
  parameter int DATA_BITS = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       scl_s,
  input logic       start_det,
  input logic       stop_det,
  input logic       engaged,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [7:0] cmd_instr,
  input logic [7:0] cmd_data,
  input logic       cmd_has_data
);
  localparam logic [7:0] KEEP = 8'((9'd1 << DATA_BITS) - 9'd1);

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_instr) && $stable(cmd_data) && $stable(cmd_has_data)); // R10
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe); // R9
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s || $past(start_det || stop_det)); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !engaged |-> !sda_oe); // R3
  AST_NODATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_has_data |-> cmd_data == 8'h00); // R5
  AST_DATA_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_data & ~KEEP) == 8'h00); // R7
endmodule

bind pot_i2c_rx pot_i2c_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s),
  .start_det(start_det), .stop_det(stop_det), .engaged(engaged),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_instr(cmd_instr),
  .cmd_data(cmd_data), .cmd_has_data(cmd_has_data)
);

// File: tb/pot_i2c_rx_tb.sv
`timescale 1ns/1ps
module pot_i2c_rx_tb;
  localparam int Q = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic oe_a, oe_b;
  logic [7:0] rd_byte = 8'hA5;
  logic rdy_a = 1'b1;
  logic val_a, val_b, hd_a, hd_b;
  logic [7:0] in_a, in_b, dt_a, dt_b;
  logic sda_line;
  logic win = 1'b0;
  int   n_tests = 0, n_fail = 0, stray = 0;
  bit   done = 0;
  logic [16:0] qa[$], qb[$];

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~oe_a & ~oe_b;

  pot_i2c_rx #(.DATA_BITS(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(oe_a),
    .addr_pin1(1'b1), .addr_pin0(1'b0), .rd_byte(rd_byte),
    .cmd_valid(val_a), .cmd_ready(rdy_a), .cmd_instr(in_a), .cmd_data(dt_a),
    .cmd_has_data(hd_a)
  );
  pot_i2c_rx #(.DATA_BITS(6)) u_dut6 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(oe_b),
    .addr_pin1(1'b1), .addr_pin0(1'b1), .rd_byte(8'hFF),
    .cmd_valid(val_b), .cmd_ready(1'b1), .cmd_instr(in_b), .cmd_data(dt_b),
    .cmd_has_data(hd_b)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model: every clock, compare the command port against the expected queues
  always @(negedge clk) if (rst_n && !done) begin
    if (oe_a && !win) stray++;
    if (val_a) begin
      if (qa.size() == 0) check(0, "R10/R3 unexpected command", {in_a, dt_a, hd_a}, 0);
      else begin
        check({in_a, dt_a, hd_a} == qa[0], "R4/R5/R10 command", {in_a, dt_a, hd_a}, qa[0]);
        if (rdy_a) void'(qa.pop_front());
      end
    end
    if (val_b) begin
      if (qb.size() == 0) check(0, "R7/R3 unexpected command 6-bit", {in_b, dt_b, hd_b}, 0);
      else check({in_b, dt_b, hd_b} == qb.pop_front(), "R7 6-bit command", {in_b, dt_b, hd_b}, qb[0]);
    end
  end

  task automatic bitx(input logic b, output logic s);
    sda_m = b; #Q; scl_m = 1'b1; #Q; s = sda_line; #Q; scl_m = 1'b0; #Q;
  endtask
  task automatic start_c();
    sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
  endtask
  task automatic stop_c();
    sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #Q;
  endtask
  task automatic wr_byte(input logic [7:0] b, input logic drive_a, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      if (i == 0) win = drive_a;
      bitx(b[i], s);
    end
    bitx(1'b1, ack);
    win = 1'b0;
  endtask
  task automatic rd_byte_m(input logic more, output logic [7:0] v);
    logic s;
    win = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      bitx(1'b1, s);
      v[i] = s;
    end
    win = more;
    bitx(~more, s);
  endtask

  initial begin : main
    logic a;
    logic [7:0] v;
    logic s;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    #(Q);
    check(oe_a == 0 && val_a == 0, "R1 reset state", {oe_a, val_a}, 0);
    check(oe_b == 0 && val_b == 0, "R1 reset state 6-bit", {oe_b, val_b}, 0);

    // R2 R4: full write
    qa.push_back({8'h12, 8'hC7, 1'b1});
    start_c();
    wr_byte(8'h5C, 1, a); check(a == 0, "R2 address ack", a, 0);
    wr_byte(8'h12, 1, a); check(a == 0, "R2 instruction ack", a, 0);
    wr_byte(8'hC7, 1, a); check(a == 0, "R2 data ack", a, 0);
    stop_c();

    // R5: instruction only, closed by STOP
    qa.push_back({8'hB0, 8'h00, 1'b0});
    start_c();
    wr_byte(8'h5C, 1, a);
    wr_byte(8'hB0, 1, a);
    stop_c();

    // R6: STOP after four data bits
    start_c();
    wr_byte(8'h5C, 1, a);
    wr_byte(8'h33, 1, a);
    for (int i = 0; i < 4; i++) bitx(1'b1, s);
    stop_c();
    #(4*Q);
    check(qa.size() == 0 && val_a == 0, "R6 truncated frame gives no command", qa.size(), 0);

    // R3: address mismatch
    start_c();
    wr_byte(8'h50, 0, a); check(a == 1, "R3 mismatch address nack", a, 1);
    wr_byte(8'h11, 0, a); check(a == 1, "R3 mismatch byte nack", a, 1);
    wr_byte(8'h22, 0, a); check(a == 1, "R3 mismatch byte nack", a, 1);
    stop_c();

    // R11: extra byte not acknowledged
    qa.push_back({8'h44, 8'h55, 1'b1});
    start_c();
    wr_byte(8'h5C, 1, a);
    wr_byte(8'h44, 1, a);
    wr_byte(8'h55, 1, a);
    wr_byte(8'h66, 0, a); check(a == 1, "R11 extra byte nack", a, 1);
    stop_c();

    // R5: repeated START after instruction
    qa.push_back({8'h77, 8'h00, 1'b0});
    qa.push_back({8'h88, 8'h99, 1'b1});
    start_c();
    wr_byte(8'h5C, 1, a);
    wr_byte(8'h77, 1, a);
    start_c();
    wr_byte(8'h5C, 1, a); check(a == 0, "R5 address ack after repeated start", a, 0);
    wr_byte(8'h88, 1, a);
    wr_byte(8'h99, 1, a);
    stop_c();

    // R7: 6-bit device masks D7..D6
    qb.push_back({8'h01, 8'h3F, 1'b1});
    start_c();
    wr_byte(8'h5E, 0, a); check(a == 0, "R7 6-bit device address ack", a, 0);
    wr_byte(8'h01, 0, a);
    wr_byte(8'hFF, 0, a);
    stop_c();
    #(4*Q);
    check(qb.size() == 0, "R7 6-bit command delivered", qb.size(), 0);

    // R10: back-pressure, second command dropped
    rdy_a = 1'b0;
    qa.push_back({8'hA1, 8'hB2, 1'b1});
    start_c();
    wr_byte(8'h5C, 1, a); wr_byte(8'hA1, 1, a); wr_byte(8'hB2, 1, a);
    stop_c();
    start_c();
    wr_byte(8'h5C, 1, a); wr_byte(8'hC3, 1, a); wr_byte(8'hD4, 1, a);
    stop_c();
    check(val_a == 1 && in_a == 8'hA1, "R10 held command", {val_a, in_a}, {1'b1, 8'hA1});
    @(negedge clk); rdy_a = 1'b1;
    #(4*Q);
    check(qa.size() == 0 && val_a == 0, "R10 single transfer, second dropped", {qa.size(), val_a}, 0);

    // R8 R9: read two bytes
    rd_byte = 8'hA5;
    start_c();
    wr_byte(8'h5D, 1, a); check(a == 0, "R2 read address ack", a, 0);
    rd_byte = 8'h3C;
    rd_byte_m(1, v); check(v == 8'hA5, "R8 first read byte captured at ack", v, 8'hA5);
    rd_byte_m(0, v); check(v == 8'h3C, "R9 reloaded after master ack", v, 8'h3C);
    #Q;
    check(oe_a == 0, "R9 released after nack", oe_a, 0);
    stop_c();
    #(4*Q);
    check(stray == 0, "R12/R3 no drive outside ack and read slots", stray, 0);
    check(qa.size() == 0 && qb.size() == 0, "R4 all commands seen", qa.size() + qb.size(), 0);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      check(0, "watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule